// File: doc/BRIEF.md
# Elapsed Time Counter with Alarm

This block keeps a free-running 48-bit count of ticks from a 32768 Hz enable strobe. The lowest 15 bits are therefore the fraction of a second and bits 47:15 are whole seconds. Software reaches the count and a 48-bit alarm value through a plain 16-bit register port with byte offsets. Each 48-bit quantity is split into three 16-bit slices: low, middle and high. Reads come straight from the live registers with no snapshot. A carry between slices can therefore tear a value read in several accesses, and software reads twice to get a consistent result.

An alarm state machine watches the count. It has three states. `ALM_IDLE` means the compare value is zero and the alarm is disarmed. `ALM_ARMED` means the compare value is non-zero. `ALM_FIRED` drives the interrupt output high.

The transitions are these:
- IDLE to ARMED when the compare value becomes non-zero.
- ARMED to IDLE when the compare value returns to zero.
- IDLE or ARMED to FIRED on a match.
- FIRED stays FIRED on a further match.
- FIRED to ARMED on acknowledge, or to IDLE on acknowledge if the compare value is zero.

A match is a tick whose incremented count equals a non-zero compare value.

Top module: `elapsed_timer`

## Requirements
- R1: After reset the counter and compare registers are zero and `alarm_irq_o` is low.
- R2: In a cycle with `tick_i` high and no counter write, the counter advances by one at the clock edge. Without a tick it holds its value.
- R3: With `addr_i` at 0x00, 0x02 or 0x04, `rd_data_o` combinationally returns counter bits 15:0, 31:16 and 47:32. With `addr_i` at 0x08, 0x0A or 0x0C, it returns the same slices of the compare value. A carry out of one slice is visible in the next slice in the same cycle as the count change.
- R4: A write (`wr_en_i` high) to a counter offset replaces only that 16-bit slice at the clock edge. A tick in the same cycle is dropped, and counting resumes from the written value on the next tick.
- R5: A write to a compare offset replaces only that 16-bit slice of the compare value at the clock edge.
- R6: When a tick makes the counter equal a non-zero compare value, `alarm_irq_o` goes high at the same edge at which the counter takes that value. It stays high through later ticks until acknowledged.
- R7: While the compare value is zero the alarm never fires, including when the counter passes through zero.
- R8: `alarm_ack_i` high for one cycle clears `alarm_irq_o` at the next edge. A match in the same cycle wins, and the output stays high.
- R9: Offsets other than the six of R3 read as zero and ignore writes. This covers odd addresses, 0x06, 0x0E and 0x10 to 0x1F.
- R10: The counter wraps from all ones to zero with no alarm raised, whatever the compare value.
- R11: Bit 15 of the low slice is bit 0 of the seconds count. A tick from low value 0x7FFF gives low value 0x8000 with the middle slice unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 32768 Hz count enable, one cycle wide |
| addr_i | input | 5 | Byte offset for read and write |
| wr_en_i | input | 1 | Write strobe for the register at `addr_i` |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Combinational read data for `addr_i` |
| alarm_ack_i | input | 1 | Clears the alarm interrupt |
| alarm_irq_o | output | 1 | Alarm interrupt, high in state ALM_FIRED |

## Verification
The bench builds the block with its defaults: three 16-bit slices, which gives a 48-bit count and a 5-bit offset. With 48 bits the wrap and the carries between slices cannot be reached by ticking alone. The bench therefore loads near-boundary values such as 0x7FFF, 0xFFFF and all ones through the counter offsets and then ticks across them. It also places compare targets a few ticks ahead of the count, so that random ticks, acknowledges and writes to reserved offsets interleave with real matches.

// File: rtl/etc_pkg.sv
package etc_pkg;

    typedef enum logic [1:0] {
        ALM_IDLE  = 2'd0,
        ALM_ARMED = 2'd1,
        ALM_FIRED = 2'd2
    } alm_state_e;

    // register group selected by the two offset bits above the slice index
    localparam logic [1:0] GRP_COUNT = 2'd0;
    localparam logic [1:0] GRP_MATCH = 2'd1;

endpackage

// File: rtl/etc_addr_decode.sv
module etc_addr_decode
    import etc_pkg::*;
#(
    parameter int NSLICE = 3,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    output logic [NSLICE-1:0] cnt_we_o,
    output logic [NSLICE-1:0] cmp_we_o,
    output logic              rd_cnt_o,
    output logic              rd_cmp_o,
    output logic [IDX_W-1:0]  rd_idx_o
);

    logic [IDX_W-1:0] idx;
    logic [1:0]       grp;
    logic             aligned;
    logic             idx_ok;

    assign idx     = addr_i[IDX_W:1];
    assign grp     = addr_i[ADDR_W-1:IDX_W+1];
    assign aligned = ~addr_i[0];
    assign idx_ok  = ({1'b0, idx} < (IDX_W+1)'(NSLICE));

    assign rd_cnt_o = aligned & idx_ok & (grp == GRP_COUNT);
    assign rd_cmp_o = aligned & idx_ok & (grp == GRP_MATCH);
    assign rd_idx_o = idx;

    for (genvar g = 0; g < NSLICE; g++) begin : g_we
        assign cnt_we_o[g] = wr_en_i & rd_cnt_o & (idx == IDX_W'(g));
        assign cmp_we_o[g] = wr_en_i & rd_cmp_o & (idx == IDX_W'(g));
    end

endmodule

// File: rtl/etc_counter.sv
module etc_counter #(
    parameter int DATA_W = 16,
    parameter int NSLICE = 3,
    localparam int CNT_W = DATA_W * NSLICE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NSLICE-1:0] we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  inc_o,
    output logic              step_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             any_we;

    assign any_we = |we_i;
    assign inc_o  = cnt_q + CNT_W'(1);
    assign step_o = tick_i & ~any_we;

    // a bus write freezes the other slices for one cycle; the tick is dropped
    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        assign cnt_d[g*DATA_W +: DATA_W] =
            any_we ? (we_i[g] ? wdata_i : cnt_q[g*DATA_W +: DATA_W]) :
            tick_i ? inc_o[g*DATA_W +: DATA_W] :
                     cnt_q[g*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/etc_compare.sv
module etc_compare #(
    parameter int DATA_W = 16,
    parameter int NSLICE = 3,
    localparam int CNT_W = DATA_W * NSLICE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLICE-1:0] we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              cmp_nz_o
);

    logic [CNT_W-1:0] cmp_q;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        always_ff @(posedge clk) begin
            if (!rst_n)     cmp_q[g*DATA_W +: DATA_W] <= '0;
            else if (we_i[g]) cmp_q[g*DATA_W +: DATA_W] <= wdata_i;
        end
    end

    assign cmp_o    = cmp_q;
    assign cmp_nz_o = |cmp_q;

endmodule

// File: rtl/etc_alarm_fsm.sv
module etc_alarm_fsm
    import etc_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] next_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             cmp_nz_i,
    input  logic             ack_i,
    output logic             irq_o
);

    alm_state_e state_q;
    alm_state_e state_d;
    logic       hit;

    assign hit = step_i & cmp_nz_i & (next_i == cmp_i);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ALM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE: begin
                if (hit)           state_d = ALM_FIRED;
                else if (cmp_nz_i) state_d = ALM_ARMED;
            end
            ALM_ARMED: begin
                if (hit)            state_d = ALM_FIRED;
                else if (!cmp_nz_i) state_d = ALM_IDLE;
            end
            ALM_FIRED: begin
                if (hit)        state_d = ALM_FIRED;
                else if (ack_i) state_d = cmp_nz_i ? ALM_ARMED : ALM_IDLE;
            end
            default:            state_d = ALM_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ALM_FIRED);
    end

endmodule

// File: rtl/etc_read_mux.sv
module etc_read_mux #(
    parameter int DATA_W = 16,
    parameter int NSLICE = 3,
    parameter int IDX_W  = 2,
    localparam int CNT_W = DATA_W * NSLICE,
    localparam int NPOS  = 1 << IDX_W
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  cmp_i,
    input  logic              rd_cnt_i,
    input  logic              rd_cmp_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] cnt_sl [NPOS];
    logic [DATA_W-1:0] cmp_sl [NPOS];

    for (genvar g = 0; g < NPOS; g++) begin : g_pos
        if (g < NSLICE) begin : g_live
            assign cnt_sl[g] = cnt_i[g*DATA_W +: DATA_W];
            assign cmp_sl[g] = cmp_i[g*DATA_W +: DATA_W];
        end else begin : g_hole
            assign cnt_sl[g] = '0;
            assign cmp_sl[g] = '0;
        end
    end

    always_comb begin
        if (rd_cnt_i)      data_o = cnt_sl[idx_i];
        else if (rd_cmp_i) data_o = cmp_sl[idx_i];
        else               data_o = '0;
    end

endmodule

// File: rtl/elapsed_timer.sv
module elapsed_timer #(
    parameter int DATA_W  = 16,
    parameter int NSLICE  = 3,
    localparam int IDX_W  = $clog2(NSLICE),
    localparam int ADDR_W = IDX_W + 3,
    localparam int CNT_W  = DATA_W * NSLICE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              alarm_ack_i,
    output logic              alarm_irq_o
);

    logic [NSLICE-1:0] cnt_we;
    logic [NSLICE-1:0] cmp_we;
    logic              rd_cnt;
    logic              rd_cmp;
    logic [IDX_W-1:0]  rd_idx;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cmp_q;
    logic              cmp_nz;
    logic              step;

    etc_addr_decode #(.NSLICE(NSLICE), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .cnt_we_o (cnt_we),
        .cmp_we_o (cmp_we),
        .rd_cnt_o (rd_cnt),
        .rd_cmp_o (rd_cmp),
        .rd_idx_o (rd_idx)
    );

    etc_counter #(.DATA_W(DATA_W), .NSLICE(NSLICE)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .we_i    (cnt_we),
        .wdata_i (wr_data_i),
        .cnt_o   (cnt_q),
        .inc_o   (cnt_inc),
        .step_o  (step)
    );

    etc_compare #(.DATA_W(DATA_W), .NSLICE(NSLICE)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cmp_we),
        .wdata_i  (wr_data_i),
        .cmp_o    (cmp_q),
        .cmp_nz_o (cmp_nz)
    );

    etc_alarm_fsm #(.CNT_W(CNT_W)) u_alm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .next_i   (cnt_inc),
        .cmp_i    (cmp_q),
        .cmp_nz_i (cmp_nz),
        .ack_i    (alarm_ack_i),
        .irq_o    (alarm_irq_o)
    );

    etc_read_mux #(.DATA_W(DATA_W), .NSLICE(NSLICE), .IDX_W(IDX_W)) u_rd (
        .cnt_i    (cnt_q),
        .cmp_i    (cmp_q),
        .rd_cnt_i (rd_cnt),
        .rd_cmp_i (rd_cmp),
        .idx_i    (rd_idx),
        .data_o   (rd_data_o)
    );

endmodule

// File: rtl/etc_timer_chk.sv
module etc_timer_chk #(
    parameter int DATA_W = 16,
    parameter int NSLICE = 3,
    localparam int CNT_W = DATA_W * NSLICE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic              addr_lsb,
    input logic              alarm_ack_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              alarm_irq_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp_q
);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_en_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(cnt_q));

    assert_fire_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq_o) |-> (cnt_q == $past(cmp_q)));

    assert_zero_cmp_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q == '0 && !alarm_irq_o) |=> !alarm_irq_o);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_ack_i && !tick_i) |=> !alarm_irq_o);

    assert_odd_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_lsb |-> (rd_data_o == '0));

    assert_wrap_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_en_i && (&cnt_q)) |=> (cnt_q == '0 && !$rose(alarm_irq_o)));

endmodule

bind elapsed_timer etc_timer_chk #(.DATA_W(DATA_W), .NSLICE(NSLICE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .addr_lsb    (addr_i[0]),
    .alarm_ack_i (alarm_ack_i),
    .rd_data_o   (rd_data_o),
    .alarm_irq_o (alarm_irq_o),
    .cnt_q       (cnt_q),
    .cmp_q       (cmp_q)
);

// File: tb/tb_elapsed_timer.sv
`timescale 1ns/1ps
module tb_elapsed_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        alarm_ack_i = 1'b0;
    logic        alarm_irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [47:0] m_cnt = '0;
    logic [47:0] m_cmp = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    elapsed_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .addr_i      (addr_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .rd_data_o   (rd_data_o),
        .alarm_ack_i (alarm_ack_i),
        .alarm_irq_o (alarm_irq_o)
    );

    // offset map of R3 and R9
    function automatic logic is_cnt(input logic [4:0] a);
        return !a[0] && a[4:3] == 2'd0 && a[2:1] != 2'd3;
    endfunction
    function automatic logic is_cmp(input logic [4:0] a);
        return !a[0] && a[4:3] == 2'd1 && a[2:1] != 2'd3;
    endfunction
    function automatic logic [15:0] exp_read(input logic [4:0] a);
        if (is_cnt(a)) return m_cnt[a[2:1]*16 +: 16];
        if (is_cmp(a)) return m_cmp[a[2:1]*16 +: 16];
        return 16'h0;
    endfunction

    task automatic model_step(input logic t, input logic w, input logic [4:0] a,
                              input logic [15:0] d, input logic k);
        logic [47:0] nxt;
        logic        cw;
        logic        fire;
        cw   = w && is_cnt(a);
        nxt  = m_cnt + 48'd1;
        fire = t && !cw && m_cmp != 48'd0 && nxt == m_cmp;
        m_irq = fire ? 1'b1 : (k ? 1'b0 : m_irq);
        if (cw)     m_cnt[a[2:1]*16 +: 16] = d;
        else if (t) m_cnt = nxt;
        if (w && is_cmp(a)) m_cmp[a[2:1]*16 +: 16] = d;
    endtask

    task automatic cyc(input logic t, input logic w, input logic [4:0] a,
                       input logic [15:0] d, input logic k);
        tick_i = t; wr_en_i = w; addr_i = a; wr_data_i = d; alarm_ack_i = k;
        @(posedge clk);
        model_step(t, w, a, d, k);
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0; alarm_ack_i = 1'b0;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [4:0] a);
        addr_i = a;
        #1;
        chk($sformatf("%s rd@%h", req, a), rd_data_o, exp_read(a));
    endtask

    task automatic chk_irq(input string req);
        chk($sformatf("%s irq", req), {15'd0, alarm_irq_o}, {15'd0, m_irq});
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < 3; i++) chk_rd(req, 5'(2*i));
        for (int i = 0; i < 3; i++) chk_rd(req, 5'(8 + 2*i));
        chk_irq(req);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        cyc(1'b0, 1'b1, a, d, 1'b0);
    endtask

    task automatic tick();
        cyc(1'b1, 1'b0, 5'd0, 16'h0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] tgt;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 low", rd_data_o, 16'h0);
        chk_all("R1");

        // R2: ticks and holds
        for (int i = 0; i < 5; i++) begin tick(); cyc(1'b0, 1'b0, 5'd0, 16'h0, 1'b0); end
        addr_i = 5'd0; #1;
        chk("R2 five ticks", rd_data_o, 16'h0005);

        // R11: seconds bit 0 sits at low bit 15
        wr(5'h00, 16'h7FFF); wr(5'h02, 16'h1234);
        tick();
        addr_i = 5'h00; #1; chk("R11 low", rd_data_o, 16'h8000);
        addr_i = 5'h02; #1; chk("R11 mid", rd_data_o, 16'h1234);

        // R3: carry into the middle slice is seen live
        wr(5'h00, 16'hFFFF);
        tick();
        addr_i = 5'h02; #1; chk("R3 carry mid", rd_data_o, 16'h1235);
        chk_all("R3");

        // R4: slice write drops the tick of the same cycle
        cyc(1'b1, 1'b1, 5'h02, 16'hABCD, 1'b0);
        addr_i = 5'h00; #1; chk("R4 low kept", rd_data_o, 16'h0000);
        addr_i = 5'h02; #1; chk("R4 mid written", rd_data_o, 16'hABCD);
        tick();
        chk_all("R4");

        // R5, R6: compare setup and match
        wr(5'h00, 16'h0100); wr(5'h02, 16'h0000); wr(5'h04, 16'h0000);
        wr(5'h08, 16'h0103);
        chk_all("R5");
        tick(); tick();
        chk("R6 before match", {15'd0, alarm_irq_o}, 16'h0);
        tick();
        chk("R6 at match", {15'd0, alarm_irq_o}, 16'h1);
        tick();
        chk("R6 sticky", {15'd0, alarm_irq_o}, 16'h1);

        // R8: acknowledge, and match beating acknowledge
        cyc(1'b0, 1'b0, 5'h00, 16'h0, 1'b1);
        chk("R8 ack clears", {15'd0, alarm_irq_o}, 16'h0);
        wr(5'h00, 16'h0102);
        cyc(1'b1, 1'b0, 5'h00, 16'h0, 1'b1);
        chk("R8 match wins", {15'd0, alarm_irq_o}, 16'h1);
        cyc(1'b0, 1'b0, 5'h00, 16'h0, 1'b1);
        chk_irq("R8");

        // R7, R10: zero compare and wrap
        wr(5'h08, 16'h0000);
        wr(5'h00, 16'hFFFF); wr(5'h02, 16'hFFFF); wr(5'h04, 16'hFFFF);
        tick();
        chk("R10 wrapped low", rd_data_o, 16'h0000);
        chk("R7 zero compare silent", {15'd0, alarm_irq_o}, 16'h0);
        chk_all("R7");
        wr(5'h08, 16'h0005);
        wr(5'h00, 16'hFFFF); wr(5'h02, 16'hFFFF); wr(5'h04, 16'hFFFF);
        tick();
        chk("R10 no flag on wrap", {15'd0, alarm_irq_o}, 16'h0);
        chk_all("R10");

        // R9: reserved offsets
        wr(5'h06, 16'hFFFF); wr(5'h0E, 16'hFFFF); wr(5'h09, 16'h1111);
        wr(5'h01, 16'h2222); wr(5'h12, 16'h3333); wr(5'h1C, 16'h4444);
        chk_rd("R9", 5'h06); chk_rd("R9", 5'h0E); chk_rd("R9", 5'h01);
        chk_rd("R9", 5'h10); chk_rd("R9", 5'h1E); chk_rd("R9", 5'h0B);
        chk_all("R9");

        // random mix (R2 R4 R5 R6 R8 R9)
        for (int n = 0; n < 4000; n++) begin
            int unsigned op;
            op = $urandom % 16;
            if (op == 0) begin
                cyc(1'($urandom), 1'b1, 5'(2 * ($urandom % 3)), 16'($urandom), 1'b0);
            end else if (op == 1) begin
                tgt = m_cnt + 48'd6 + 48'($urandom % 8);
                for (int s = 0; s < 3; s++)
                    cyc(1'($urandom % 2), 1'b1, 5'(8 + 2*s), tgt[s*16 +: 16], 1'b0);
            end else if (op == 2) begin
                cyc(1'($urandom), 1'b1, 5'($urandom), 16'($urandom), 1'b0);
            end else if (op == 3) begin
                cyc(1'($urandom), 1'b0, 5'd0, 16'h0, 1'b1);
            end else begin
                cyc(($urandom % 4) != 0, 1'b0, 5'd0, 16'h0, 1'b0);
            end
            chk_irq("R6/R8 random");
            chk_rd("R2/R4/R9 random", 5'($urandom));
        end
        chk_all("R5 final");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule